// File: doc/BRIEF.md
# Multicycle Load/Store Processor Core

A 32-bit processor core that spreads each instruction over three to five clock cycles. It shares one adder/subtractor and one memory port across those cycles. It supports six instructions: register add, register subtract, word load, word store, branch-if-equal and an absolute jump. One memory holds both instructions and data. A finite-state controller sequences each instruction through these steps: fetch, decode, then a per-class execute, memory and write-back stage.

The internal holding registers are the program counter, the instruction register, the memory data register, the two operand latches and the ALU result latch. All of them change only at a clock edge. The operand latches and the result latch reload on every cycle, whether or not the next step uses them. The memory data register holds zero on every cycle that does not read memory. All holding registers and the current controller state are visible on debug outputs, so a whole instruction stream can be traced cycle by cycle. A testbench loads the memory image through a task of the memory submodule.

Top module: `mc_core`

## Requirements
- R1: While the active-low asynchronous reset is held, the program counter reads 4000, and the instruction, memory data, operand A, operand B and ALU result registers read 0. The state is fetch (0) and every register-file entry is 0.
- R2: A fetch cycle loads the memory word addressed by PC into both the instruction register and the memory data register. At the same edge, PC and the ALU result register both become PC+4. PC changes only in fetch, a taken branch or a jump.
- R3: Operands A and B are reloaded on every cycle from the register-file entries selected by IR[25:21] and IR[20:16] of the instruction register as it stands during that cycle.
- R4: The ALU result register captures the ALU output on every cycle. In decode, that output is PC + (sign-extended IR[15:0] shifted left by 2). In cycles that set no ALU control, it is PC + B.
- R5: The memory data register loads 0 on every cycle other than fetch and the load's read cycle. In the read cycle, it loads the data word at the byte address held in the ALU result register.
- R6: Opcode 000000 is register arithmetic. Funct 100000 adds A+B and funct 100010 subtracts A-B. The result is written to the register at IR[15:11] in the fourth cycle.
- R7: Opcode 100011 (load) and opcode 101011 (store) both form the address A + sign-extended IR[15:0]. A load takes 5 cycles and writes the memory data register into the register at IR[20:16]. A store takes 4 cycles and writes B to memory.
- R8: Opcode 000100 (branch-if-equal) takes 3 cycles. When A equals B, PC becomes PC+4 + 4*offset. Otherwise PC is left unchanged after fetch.
- R9: Opcode 000010 (jump) takes 3 cycles and sets PC to {PC[31:28], IR[25:0], 2'b00}.
- R10: Register 0 always reads as 0, and writes to it are discarded.
- R11: The state output encodes fetch=0, decode=1, address=2, read=3, load write-back=4, store=5, execute=6, arithmetic write-back=7, branch=8, jump=9. Decode always follows fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_o | output | 32 | Program counter |
| ir_o | output | 32 | Instruction register |
| mdr_o | output | 32 | Memory data register |
| a_o | output | 32 | Operand A latch |
| b_o | output | 32 | Operand B latch |
| alu_out_o | output | 32 | ALU result latch |
| state_o | output | 4 | Current controller state |

## Verification
A twelve-instruction program is traced cycle by cycle against a hand-derived table of state, PC, operands, result latch and data register. The program contains two back-to-back loads, a subtraction whose result is stored and later reloaded, and an addition aimed at register 0 that is then read back. It also has a branch that falls through, a branch that is taken over a junk word, and a jump over another junk word. The fall-through and taken branches separate the compare-and-select path from the plain fetch increment. The store/reload round trip separates the address and data paths of the shared memory port. The register-0 write shows whether the zero register is protected. A reset asserted mid-program, followed by a restart from 4000, checks the asynchronous clear.

// File: rtl/mc_core_pkg.sv
package mc_core_pkg;
  localparam int XLEN = 32;
  localparam int ST_W = 4;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;
  localparam logic [5:0] FN_ADD   = 6'b100000;
  localparam logic [5:0] FN_SUB   = 6'b100010;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH     = 4'd0,
    ST_DECODE    = 4'd1,
    ST_MEM_ADDR  = 4'd2,
    ST_MEM_READ  = 4'd3,
    ST_MEM_WB    = 4'd4,
    ST_MEM_WRITE = 4'd5,
    ST_EXEC      = 4'd6,
    ST_R_WB      = 4'd7,
    ST_BRANCH    = 4'd8,
    ST_JUMP      = 4'd9
  } state_e;

  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_SUB = 2'd1, ALU_FUNCT = 2'd2} alu_op_e;
  typedef enum logic [1:0] {SRCB_REG = 2'd0, SRCB_FOUR = 2'd1, SRCB_IMM = 2'd2, SRCB_IMM_SH = 2'd3} src_b_e;
  typedef enum logic [1:0] {PCS_ALU = 2'd0, PCS_ALUOUT = 2'd1, PCS_JUMP = 2'd2} pc_src_e;

  typedef struct packed {
    logic    mem_read;
    logic    mem_write;
    logic    iord;
    logic    ir_write;
    logic    alu_src_a;
    src_b_e  alu_src_b;
    alu_op_e alu_op;
    pc_src_e pc_src;
    logic    pc_write;
    logic    pc_write_cond;
    logic    reg_dst;
    logic    mem_to_reg;
    logic    reg_write;
  } ctrl_t;
endpackage

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mc_core_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [5:0] opcode_i,
  output ctrl_t      ctrl_o,
  output state_e     state_o
);
  state_e state_q, state_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  always_comb begin
    ctrl_o  = '0;  // idle ALU setup: PC + B
    state_d = ST_FETCH;
    case (state_q)
      ST_FETCH: begin
        ctrl_o.mem_read  = 1'b1;
        ctrl_o.ir_write  = 1'b1;
        ctrl_o.alu_src_b = SRCB_FOUR;
        ctrl_o.pc_write  = 1'b1;
        state_d          = ST_DECODE;
      end
      ST_DECODE: begin
        ctrl_o.alu_src_b = SRCB_IMM_SH;
        case (opcode_i)
          OP_LW, OP_SW: state_d = ST_MEM_ADDR;
          OP_RTYPE:     state_d = ST_EXEC;
          OP_BEQ:       state_d = ST_BRANCH;
          OP_J:         state_d = ST_JUMP;
          default:      state_d = ST_FETCH;
        endcase
      end
      ST_MEM_ADDR: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_src_b = SRCB_IMM;
        state_d = (opcode_i == OP_LW) ? ST_MEM_READ : ST_MEM_WRITE;
      end
      ST_MEM_READ: begin
        ctrl_o.mem_read = 1'b1;
        ctrl_o.iord     = 1'b1;
        state_d         = ST_MEM_WB;
      end
      ST_MEM_WB: begin
        ctrl_o.reg_write  = 1'b1;
        ctrl_o.mem_to_reg = 1'b1;
      end
      ST_MEM_WRITE: begin
        ctrl_o.mem_write = 1'b1;
        ctrl_o.iord      = 1'b1;
      end
      ST_EXEC: begin
        ctrl_o.alu_src_a = 1'b1;
        ctrl_o.alu_op    = ALU_FUNCT;
        state_d          = ST_R_WB;
      end
      ST_R_WB: begin
        ctrl_o.reg_dst   = 1'b1;
        ctrl_o.reg_write = 1'b1;
      end
      ST_BRANCH: begin
        ctrl_o.alu_src_a     = 1'b1;
        ctrl_o.alu_op        = ALU_SUB;
        ctrl_o.pc_src        = PCS_ALUOUT;
        ctrl_o.pc_write_cond = 1'b1;
      end
      ST_JUMP: begin
        ctrl_o.pc_src   = PCS_JUMP;
        ctrl_o.pc_write = 1'b1;
      end
      default: state_d = ST_FETCH;
    endcase
  end

  assign state_o = state_q;

  AST_DECODE_AFTER_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_FETCH |=> state_q == ST_DECODE);  // R11
  AST_LOAD_READ_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_MEM_READ |=> state_q == ST_MEM_WB);  // R7
endmodule

// File: rtl/mc_alu.sv
module mc_alu
  import mc_core_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [5:0]      funct_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o,
  output logic            zero_o
);
  logic do_sub;

  always_comb begin
    case (op_i)
      ALU_SUB:   do_sub = 1'b1;
      ALU_FUNCT: do_sub = (funct_i == FN_SUB);  // other functs add
      default:   do_sub = 1'b0;
    endcase
  end

  assign y_o    = do_sub ? (a_i - b_i) : (a_i + b_i);
  assign zero_o = (y_o == '0);
endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
  import mc_core_pkg::*;
#(
  parameter int NREG = 32,
  localparam int RA_W = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [RA_W-1:0] ra_a_i,
  input  logic [RA_W-1:0] ra_b_i,
  input  logic            we_i,
  input  logic [RA_W-1:0] wa_i,
  input  logic [XLEN-1:0] wd_i,
  output logic [XLEN-1:0] rd_a_o,
  output logic [XLEN-1:0] rd_b_o
);
  logic [XLEN-1:0] rf_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
    end else if (we_i && wa_i != '0) begin
      rf_q[wa_i] <= wd_i;
    end
  end

  assign rd_a_o = (ra_a_i == '0) ? '0 : rf_q[ra_a_i];
  assign rd_b_o = (ra_b_i == '0) ? '0 : rf_q[ra_b_i];

  AST_ZERO_REG_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_q[0] == '0);  // R10
endmodule

// File: rtl/mc_mem.sv
module mc_mem
  import mc_core_pkg::*;
#(
  parameter int AW = 12,
  localparam int DEPTH = 1 << AW
) (
  input  logic            clk_i,
  input  logic            we_i,
  input  logic [AW-1:0]   idx_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[idx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[idx_i];

  // image preload by the testbench, word index = byte address / 4
  task automatic load_word(input logic [AW-1:0] idx, input logic [XLEN-1:0] val);
    mem_q[idx] <= val;
  endtask
endmodule

// File: rtl/mc_core.sv
module mc_core
  import mc_core_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = 32'd4000,
  parameter int              MEM_AW   = 12,
  parameter int              NREG     = 32,
  localparam int             RA_W     = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] ir_o,
  output logic [XLEN-1:0] mdr_o,
  output logic [XLEN-1:0] a_o,
  output logic [XLEN-1:0] b_o,
  output logic [XLEN-1:0] alu_out_o,
  output logic [ST_W-1:0] state_o
);
  logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_out_q;
  logic [XLEN-1:0] imm_ext, imm_sh, src_a, src_b, alu_y, pc_next;
  logic [XLEN-1:0] mem_rdata, rf_rd_a, rf_rd_b, rf_wd;
  logic [RA_W-1:0] rf_wa;
  logic [MEM_AW-1:0] mem_idx;
  logic            alu_zero, pc_en;
  ctrl_t           ctrl;
  state_e          state;

  mc_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (ir_q[31:26]),
    .ctrl_o   (ctrl),
    .state_o  (state)
  );

  assign imm_ext = {{(XLEN-16){ir_q[15]}}, ir_q[15:0]};
  assign imm_sh  = {imm_ext[XLEN-3:0], 2'b00};
  assign src_a   = ctrl.alu_src_a ? a_q : pc_q;

  always_comb begin
    case (ctrl.alu_src_b)
      SRCB_REG:  src_b = b_q;
      SRCB_FOUR: src_b = XLEN'(4);
      SRCB_IMM:  src_b = imm_ext;
      default:   src_b = imm_sh;
    endcase
  end

  mc_alu u_alu (
    .op_i    (ctrl.alu_op),
    .funct_i (ir_q[5:0]),
    .a_i     (src_a),
    .b_i     (src_b),
    .y_o     (alu_y),
    .zero_o  (alu_zero)
  );

  assign rf_wa = ctrl.reg_dst ? ir_q[15:11] : ir_q[20:16];
  assign rf_wd = ctrl.mem_to_reg ? mdr_q : alu_out_q;

  mc_regfile #(.NREG(NREG)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_a_i (ir_q[25:21]),
    .ra_b_i (ir_q[20:16]),
    .we_i   (ctrl.reg_write),
    .wa_i   (rf_wa),
    .wd_i   (rf_wd),
    .rd_a_o (rf_rd_a),
    .rd_b_o (rf_rd_b)
  );

  assign mem_idx = ctrl.iord ? alu_out_q[MEM_AW+1:2] : pc_q[MEM_AW+1:2];

  mc_mem #(.AW(MEM_AW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (ctrl.mem_write),
    .idx_i   (mem_idx),
    .wdata_i (b_q),
    .rdata_o (mem_rdata)
  );

  always_comb begin
    case (ctrl.pc_src)
      PCS_ALU:    pc_next = alu_y;
      PCS_ALUOUT: pc_next = alu_out_q;
      default:    pc_next = {pc_q[XLEN-1:XLEN-4], ir_q[25:0], 2'b00};
    endcase
  end

  assign pc_en = ctrl.pc_write | (ctrl.pc_write_cond & alu_zero);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q      <= RESET_PC;
      ir_q      <= '0;
      mdr_q     <= '0;
      a_q       <= '0;
      b_q       <= '0;
      alu_out_q <= '0;
    end else begin
      if (pc_en)        pc_q <= pc_next;
      if (ctrl.ir_write) ir_q <= mem_rdata;
      mdr_q     <= ctrl.mem_read ? mem_rdata : '0;  // shared memory output
      a_q       <= rf_rd_a;                         // no enables
      b_q       <= rf_rd_b;
      alu_out_q <= alu_y;
    end
  end

  assign pc_o      = pc_q;
  assign ir_o      = ir_q;
  assign mdr_o     = mdr_q;
  assign a_o       = a_q;
  assign b_o       = b_q;
  assign alu_out_o = alu_out_q;
  assign state_o   = state;

  AST_FETCH_ADVANCES_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_FETCH |=> pc_q == $past(pc_q) + 32'd4 && alu_out_q == pc_q);  // R2
  AST_PC_HELD_ELSEWHERE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state inside {ST_FETCH, ST_BRANCH, ST_JUMP}) |=> $stable(pc_q));  // R2
  AST_FETCH_IR_EQ_MDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_FETCH |=> ir_q == mdr_q);  // R2
  AST_MDR_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(state inside {ST_FETCH, ST_MEM_READ}) |=> mdr_q == '0);  // R5
  AST_BRANCH_UNEQUAL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_BRANCH && a_q != b_q |=> $stable(pc_q));  // R8
  AST_BRANCH_EQUAL_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_BRANCH && a_q == b_q |=> pc_q == $past(alu_out_q));  // R8
  AST_JUMP_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state == ST_JUMP |=> pc_q == {$past(pc_q[31:28]), $past(ir_q[25:0]), 2'b00});  // R9
endmodule

// File: tb/mc_core_tb_top.sv
module mc_core_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW     = 12;
  localparam int NROWS      = 39;

  typedef struct packed {
    logic [3:0]  st;
    logic [31:0] pc, a, b, alu, mdr;
  } row_t;

  // program at byte 4000 (word 1000)
  localparam logic [31:0] PROG [12] = '{
    32'h8C011F40,  // 4000 lw  r1, 8000(r0)
    32'h8C021F44,  // 4004 lw  r2, 8004(r0)
    32'h00221822,  // 4008 sub r3, r1, r2
    32'hAC031F48,  // 4012 sw  r3, 8008(r0)
    32'h10600005,  // 4016 beq r3, r0, +5  (not taken)
    32'h00220020,  // 4020 add r0, r1, r2  (discarded)
    32'h10000001,  // 4024 beq r0, r0, +1  (taken)
    32'h00212020,  // 4028 skipped
    32'h080003F2,  // 4032 j 4040
    32'h00212020,  // 4036 skipped
    32'h8C051F48,  // 4040 lw  r5, 8008(r0)
    32'h00053020   // 4044 add r6, r0, r5
  };

  // expected after each clock edge: next state, PC, A, B, ALU result, MDR
  localparam row_t TRACE [NROWS] = '{
    '{4'd1, 32'd4004, 32'd0,   32'd0,   32'd4004,  32'h8C011F40},
    '{4'd2, 32'd4004, 32'd0,   32'd0,   32'd36004, 32'd0},
    '{4'd3, 32'd4004, 32'd0,   32'd0,   32'd8000,  32'd0},
    '{4'd4, 32'd4004, 32'd0,   32'd0,   32'd4004,  32'd134},
    '{4'd0, 32'd4004, 32'd0,   32'd0,   32'd4004,  32'd0},
    '{4'd1, 32'd4008, 32'd0,   32'd134, 32'd4008,  32'h8C021F44},
    '{4'd2, 32'd4008, 32'd0,   32'd0,   32'd36024, 32'd0},
    '{4'd3, 32'd4008, 32'd0,   32'd0,   32'd8004,  32'd0},
    '{4'd4, 32'd4008, 32'd0,   32'd0,   32'd4008,  32'd82},
    '{4'd0, 32'd4008, 32'd0,   32'd0,   32'd4008,  32'd0},
    '{4'd1, 32'd4012, 32'd0,   32'd82,  32'd4012,  32'h00221822},
    '{4'd6, 32'd4012, 32'd134, 32'd82,  32'd28724, 32'd0},
    '{4'd7, 32'd4012, 32'd134, 32'd82,  32'd52,    32'd0},
    '{4'd0, 32'd4012, 32'd134, 32'd82,  32'd4094,  32'd0},
    '{4'd1, 32'd4016, 32'd134, 32'd82,  32'd4016,  32'hAC031F48},
    '{4'd2, 32'd4016, 32'd0,   32'd52,  32'd36048, 32'd0},
    '{4'd5, 32'd4016, 32'd0,   32'd52,  32'd8008,  32'd0},
    '{4'd0, 32'd4016, 32'd0,   32'd52,  32'd4068,  32'd0},
    '{4'd1, 32'd4020, 32'd0,   32'd52,  32'd4020,  32'h10600005},
    '{4'd8, 32'd4020, 32'd52,  32'd0,   32'd4040,  32'd0},
    '{4'd0, 32'd4020, 32'd52,  32'd0,   32'd52,    32'd0},
    '{4'd1, 32'd4024, 32'd52,  32'd0,   32'd4024,  32'h00220020},
    '{4'd6, 32'd4024, 32'd134, 32'd82,  32'd4152,  32'd0},
    '{4'd7, 32'd4024, 32'd134, 32'd82,  32'd216,   32'd0},
    '{4'd0, 32'd4024, 32'd134, 32'd82,  32'd4106,  32'd0},
    '{4'd1, 32'd4028, 32'd134, 32'd82,  32'd4028,  32'h10000001},
    '{4'd8, 32'd4028, 32'd0,   32'd0,   32'd4032,  32'd0},
    '{4'd0, 32'd4032, 32'd0,   32'd0,   32'd0,     32'd0},
    '{4'd1, 32'd4036, 32'd0,   32'd0,   32'd4036,  32'h080003F2},
    '{4'd9, 32'd4036, 32'd0,   32'd0,   32'd8076,  32'd0},
    '{4'd0, 32'd4040, 32'd0,   32'd0,   32'd4036,  32'd0},
    '{4'd1, 32'd4044, 32'd0,   32'd0,   32'd4044,  32'h8C051F48},
    '{4'd2, 32'd4044, 32'd0,   32'd0,   32'd36076, 32'd0},
    '{4'd3, 32'd4044, 32'd0,   32'd0,   32'd8008,  32'd0},
    '{4'd4, 32'd4044, 32'd0,   32'd0,   32'd4044,  32'd52},
    '{4'd0, 32'd4044, 32'd0,   32'd0,   32'd4044,  32'd0},
    '{4'd1, 32'd4048, 32'd0,   32'd52,  32'd4048,  32'h00053020},
    '{4'd6, 32'd4048, 32'd0,   32'd52,  32'd53328, 32'd0},
    '{4'd7, 32'd4048, 32'd0,   32'd52,  32'd52,    32'd0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_o, ir_o, mdr_o, a_o, b_o, alu_out_o;
  logic [3:0]  state_o;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] obs_pc [NROWS];
  logic [31:0] obs_a [NROWS];
  logic [31:0] obs_alu [NROWS];
  logic [31:0] obs_mdr [NROWS];
  logic [31:0] ir_first;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_core #(.MEM_AW(MEM_AW)) dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .pc_o      (pc_o),
    .ir_o      (ir_o),
    .mdr_o     (mdr_o),
    .a_o       (a_o),
    .b_o       (b_o),
    .alu_out_o (alu_out_o),
    .state_o   (state_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d (0x%08h) expected=%0d (0x%08h)", req, what, act, act, exp, exp);
    end
  endtask

  task automatic chk_reset_state(input string tag);
    chk("R1", {tag, " pc"},    pc_o,      32'd4000);
    chk("R1", {tag, " ir"},    ir_o,      32'd0);
    chk("R1", {tag, " mdr"},   mdr_o,     32'd0);
    chk("R1", {tag, " a"},     a_o,       32'd0);
    chk("R1", {tag, " b"},     b_o,       32'd0);
    chk("R1", {tag, " alu"},   alu_out_o, 32'd0);
    chk("R1", {tag, " state"}, {28'd0, state_o}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_chk++;
    n_fail++;
    $display("FAIL R11 watchdog: actual=hung expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 12; i++) dut_i.u_mem.load_word(MEM_AW'(1000 + i), PROG[i]);
    dut_i.u_mem.load_word(MEM_AW'(2000), 32'd134);
    dut_i.u_mem.load_word(MEM_AW'(2001), 32'd82);
    dut_i.u_mem.load_word(MEM_AW'(2002), 32'd0);
    repeat (3) @(negedge clk);
    chk_reset_state("initial reset");
    rst_ni = 1'b1;

    // main table walk: one row per cycle
    for (int k = 0; k < NROWS; k++) begin
      @(negedge clk);
      if (k == 0) ir_first = ir_o;
      obs_pc[k] = pc_o; obs_a[k] = a_o; obs_alu[k] = alu_out_o; obs_mdr[k] = mdr_o;
      chk("R11", $sformatf("row %0d state", k + 1), {28'd0, state_o}, {28'd0, TRACE[k].st});
      chk("R2",  $sformatf("row %0d pc", k + 1),    pc_o,      TRACE[k].pc);
      chk("R3",  $sformatf("row %0d a", k + 1),     a_o,       TRACE[k].a);
      chk("R3",  $sformatf("row %0d b", k + 1),     b_o,       TRACE[k].b);
      chk("R4",  $sformatf("row %0d alu", k + 1),   alu_out_o, TRACE[k].alu);
      chk("R5",  $sformatf("row %0d mdr", k + 1),   mdr_o,     TRACE[k].mdr);
    end

    // directed corner cases on the recorded trace
    chk("R2",  "fetched word in IR",          ir_first,    32'h8C011F40);
    chk("R4",  "decode branch target",        obs_alu[1],  32'd36004);
    chk("R5",  "load read cycle data",        obs_mdr[3],  32'd134);
    chk("R6",  "sub result 134-82",           obs_alu[12], 32'd52);
    chk("R6",  "add result 134+82",           obs_alu[23], 32'd216);
    chk("R7",  "store then reload round trip", obs_mdr[34], 32'd52);
    chk("R7",  "load address formed",         obs_alu[2],  32'd8000);
    chk("R8",  "branch not taken keeps pc",   obs_pc[20],  32'd4020);
    chk("R8",  "branch taken target",         obs_pc[27],  32'd4032);
    chk("R9",  "jump target",                 obs_pc[30],  32'd4040);
    chk("R10", "r0 still zero after write",   obs_a[26],   32'd0);
    chk("R10", "r0 reads zero as operand",    obs_a[37],   32'd0);

    // asynchronous reset in mid-program, then restart
    @(negedge clk);
    #(CLK_PERIOD/4);
    rst_ni = 1'b0;
    #1;
    chk_reset_state("mid-run reset");
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "restart pc",    pc_o, 32'd4004);
    chk("R1", "restart fetch", ir_o, 32'h8C011F40);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule